// File: doc/BRIEF.md
# Bit, Shift and Rotate Execution Unit

This unit carries out the bit-manipulation page of an 8-bit processor's instruction set on one operand per cycle. The caller presents the second opcode byte, the operand value and the current flag byte. The unit decodes the two-bit group field, the three-bit sub-operation or bit-index field and the three-bit operand-source field. It returns the new value, the new flag byte and a write-enable. These appear one clock later, in a single register stage.

The operand-source field is decoded at once onto a select output, so the surrounding datapath can fetch the operand in the same cycle. Memory fetch for the indirect source code is done outside this unit. The rotate/shift group also contains the extra left shift. It moves bit 7 into carry and forces bit 0 to one, so its result is twice the operand plus one.

The flag byte uses the following positions: bit 7 sign (S), bit 6 zero (Z), bit 4 half-carry (H), bit 2 parity (P, 1 when the count of ones is even), bit 1 subtract (N), bit 0 carry (C). Bits 5 and 3 are always copied from the incoming flag byte.

Top module: `bitshift_unit`

## Requirements
- R1: Group is opcode bits 7:6: 00 rotate/shift, 01 bit test, 10 clear bit, 11 set bit. A request accepted with in_valid high appears on the outputs on the next rising edge, with out_valid high for exactly that cycle.
- R2: In group 00, bits 5:3 pick the operation: 0 rotate left circular, 1 rotate right circular, 2 rotate left through carry, 3 rotate right through carry, 4 arithmetic shift left (0 in), 5 arithmetic shift right (bit 7 kept), 6 extra shift left, 7 logical shift right (0 in). The bit shifted out becomes the new carry.
- R3: Operation 6 of group 00 gives {operand[6:0],1}, with carry equal to operand bit 7, whatever the incoming carry and flags are.
- R4: For group 00, S is result bit 7, Z is 1 when the result is zero, P is 1 when the result has even parity, and H and N are 0. Bits 5 and 3 are copied from flags_in. wr_en is 1.
- R5: For group 01, the bit index is opcode bits 5:3. Z is the inverse of the operand bit at that index, H is 1 and N is 0. S, P, C and bits 5 and 3 keep their flags_in values, wr_en is 0, and result equals the operand.
- R6: Group 10 clears, and group 11 sets, the operand bit given by opcode bits 5:3, for all eight positions, with wr_en 1. flags_out equals flags_in exactly.
- R7: src_sel equals opcode bits 2:0 in the same cycle, with codes 0 to 7 meaning B, C, D, E, H, L, indirect memory, A. The source code has no effect on result, flags or wr_en.
- R8: Reset (rst_n low) clears out_valid, wr_en, result and flags_out. In a cycle with in_valid low, out_valid is 0 on the next edge and result, flags_out and wr_en keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request present this cycle |
| op_code | input | 8 | Second opcode byte |
| operand | input | 8 | Operand value |
| flags_in | input | 8 | Current flag byte |
| src_sel | output | 3 | Operand source code, combinational |
| out_valid | output | 1 | Registered result valid |
| result | output | 8 | Registered new value |
| flags_out | output | 8 | Registered new flag byte |
| wr_en | output | 1 | Registered write-back enable |

## Verification
In any cycle of a back-to-back stream, the combinational source-select decode for the new request and the registered result of the previous request are both on the outputs. The bench drives every opcode with several operands, one request right after another. It also mixes in idle cycles that carry junk opcodes. In each cycle it checks src_sel against the current opcode and, after the edge, checks result, flags and wr_en against the previous request. A unit that let the new opcode leak into the registered outputs, or that failed to hold its outputs on an idle cycle, would fail these checks.

// File: rtl/bitshift_pkg.sv
package bitshift_pkg;
  localparam int DW = 8;
  localparam int IW = $clog2(DW);
  localparam int FW = 8;
  localparam int SELW = 3;

  localparam int FL_S = 7;
  localparam int FL_Z = 6;
  localparam int FL_H = 4;
  localparam int FL_P = 2;
  localparam int FL_N = 1;
  localparam int FL_C = 0;

  typedef enum logic [1:0] {
    GRP_ROT = 2'd0,
    GRP_TST = 2'd1,
    GRP_CLR = 2'd2,
    GRP_SET = 2'd3
  } grp_e;

  typedef enum logic [2:0] {
    SH_RLC = 3'd0,
    SH_RRC = 3'd1,
    SH_RL  = 3'd2,
    SH_RR  = 3'd3,
    SH_SLA = 3'd4,
    SH_SRA = 3'd5,
    SH_SLL = 3'd6,
    SH_SRL = 3'd7
  } shk_e;

  typedef struct packed {
    logic [DW-1:0] val;
    logic          cout;
  } shres_t;

  // 1 when the number of set bits is even
  function automatic logic even_par(input logic [DW-1:0] v);
    return ~^v;
  endfunction

  function automatic shres_t shift_op(input shk_e k, input logic [DW-1:0] d,
                                      input logic cin);
    shres_t r;
    unique case (k)
      SH_RLC: begin r.val = {d[DW-2:0], d[DW-1]}; r.cout = d[DW-1]; end
      SH_RRC: begin r.val = {d[0], d[DW-1:1]};    r.cout = d[0];    end
      SH_RL:  begin r.val = {d[DW-2:0], cin};     r.cout = d[DW-1]; end
      SH_RR:  begin r.val = {cin, d[DW-1:1]};     r.cout = d[0];    end
      SH_SLA: begin r.val = {d[DW-2:0], 1'b0};    r.cout = d[DW-1]; end
      SH_SRA: begin r.val = {d[DW-1], d[DW-1:1]}; r.cout = d[0];    end
      SH_SLL: begin r.val = {d[DW-2:0], 1'b1};    r.cout = d[DW-1]; end
      default: begin r.val = {1'b0, d[DW-1:1]};   r.cout = d[0];    end
    endcase
    return r;
  endfunction
endpackage

// File: rtl/bitshift_decode.sv
module bitshift_decode
  import bitshift_pkg::*;
(
  input  logic [7:0]      op,
  output grp_e            grp,
  output logic [IW-1:0]   sub,
  output logic [SELW-1:0] sel
);
  assign grp = grp_e'(op[7:6]);
  assign sub = op[5:3];
  assign sel = op[2:0];
endmodule

// File: rtl/bitshift_shifter.sv
module bitshift_shifter
  import bitshift_pkg::*;
(
  input  logic [IW-1:0] kind,
  input  logic [DW-1:0] d,
  input  logic          cin,
  output logic [DW-1:0] val,
  output logic          cout
);
  shres_t r;
  always_comb r = shift_op(shk_e'(kind), d, cin);
  assign val  = r.val;
  assign cout = r.cout;
endmodule

// File: rtl/bitshift_field.sv
module bitshift_field
  import bitshift_pkg::*;
(
  input  grp_e          grp,
  input  logic [IW-1:0] idx,
  input  logic [DW-1:0] d,
  output logic [DW-1:0] val,
  output logic          tbit
);
  for (genvar i = 0; i < DW; i++) begin : g_bit
    logic hit;
    assign hit = (idx == IW'(i));
    always_comb begin
      if (hit && grp == GRP_SET)      val[i] = 1'b1;
      else if (hit && grp == GRP_CLR) val[i] = 1'b0;
      else                            val[i] = d[i];
    end
  end
  assign tbit = d[idx];
endmodule

// File: rtl/bitshift_unit.sv
module bitshift_unit
  import bitshift_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [7:0]      op_code,
  input  logic [DW-1:0]   operand,
  input  logic [FW-1:0]   flags_in,
  output logic [SELW-1:0] src_sel,
  output logic            out_valid,
  output logic [DW-1:0]   result,
  output logic [FW-1:0]   flags_out,
  output logic            wr_en
);
  grp_e          grp;
  logic [IW-1:0] sub;
  logic [DW-1:0] sh_val, fld_val, nxt_res;
  logic          sh_cout, tst_bit;
  logic [FW-1:0] nxt_flags;
  logic          is_test, do_write;

  bitshift_decode u_dec (.op(op_code), .grp(grp), .sub(sub), .sel(src_sel));

  bitshift_shifter u_sh (.kind(sub), .d(operand), .cin(flags_in[FL_C]),
                         .val(sh_val), .cout(sh_cout));

  bitshift_field u_fld (.grp(grp), .idx(sub), .d(operand),
                        .val(fld_val), .tbit(tst_bit));

  assign is_test  = (grp == GRP_TST);
  assign do_write = !is_test;

  always_comb begin
    nxt_flags = flags_in;
    nxt_res   = fld_val;
    unique case (grp)
      GRP_ROT: begin
        nxt_res         = sh_val;
        nxt_flags[FL_S] = sh_val[DW-1];
        nxt_flags[FL_Z] = (sh_val == '0);
        nxt_flags[FL_H] = 1'b0;
        nxt_flags[FL_P] = even_par(sh_val);
        nxt_flags[FL_N] = 1'b0;
        nxt_flags[FL_C] = sh_cout;
      end
      GRP_TST: begin
        nxt_flags[FL_Z] = ~tst_bit;
        nxt_flags[FL_H] = 1'b1;
        nxt_flags[FL_N] = 1'b0;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      flags_out <= '0;
      wr_en     <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result    <= nxt_res;
        flags_out <= nxt_flags;
        wr_en     <= do_write;
      end
    end
  end
endmodule

// File: rtl/bitshift_unit_chk.sv
module bitshift_unit_chk
  import bitshift_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic [7:0]      op_code,
  input logic [DW-1:0]   operand,
  input logic [FW-1:0]   flags_in,
  input logic            out_valid,
  input logic [DW-1:0]   result,
  input logic [FW-1:0]   flags_out,
  input logic            wr_en
);
  p_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  p_rot_flags_r4: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && op_code[7:6] == 2'b00 |=>
      !flags_out[FL_H] && !flags_out[FL_N] && wr_en &&
      flags_out[FL_Z] == (result == '0) && flags_out[FL_P] == ~^result &&
      flags_out[FL_S] == result[DW-1]);

  p_sll_r3: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && op_code[7:3] == 5'b00110 |=>
      result[0] && flags_out[FL_C] == $past(operand[DW-1]));

  p_test_nowrite_r5: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && op_code[7:6] == 2'b01 |=>
      !wr_en && flags_out[FL_H] && flags_out[FL_C] == $past(flags_in[FL_C]) &&
      result == $past(operand));

  p_setclr_flags_r6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && op_code[7] |=> wr_en && flags_out == $past(flags_in));

  p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid && $stable(result) && $stable(flags_out) && $stable(wr_en));
endmodule

bind bitshift_unit bitshift_unit_chk i_chk (.*);

// File: tb/test_bitshift_unit.sv
`timescale 1ns/1ps
module test_bitshift_unit;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       in_valid;
  logic [7:0] op_code, operand, flags_in;
  logic [2:0] src_sel;
  logic       out_valid, wr_en;
  logic [7:0] result, flags_out;

  always #2.5 clk = ~clk;

  bitshift_unit i_bitshift_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_code(op_code),
    .operand(operand), .flags_in(flags_in), .src_sel(src_sel),
    .out_valid(out_valid), .result(result), .flags_out(flags_out), .wr_en(wr_en));

  int n_vec = 0;
  int n_bad = 0;

  typedef struct { bit v; bit [7:0] r; bit [7:0] f; bit w; } exp_t;
  exp_t q[$];
  bit [7:0]  m_r = 0, m_f = 0;
  bit        m_w = 0;
  bit [15:0] lfsr = 16'hACE1;

  // Reference: returns we*65536 + flags*256 + result, arithmetic style
  function automatic int ref_model(int op, int d, int fin);
    int r, co, b, f, ones, we;
    b  = (op / 8) % 8;
    we = 1;
    f  = fin;
    case (op / 64)
      0: begin
        case (b)
          0: begin r = (d * 2) % 256 + d / 128;         co = d / 128; end
          1: begin r = d / 2 + (d % 2) * 128;            co = d % 2;   end
          2: begin r = (d * 2) % 256 + fin % 2;          co = d / 128; end
          3: begin r = d / 2 + (fin % 2) * 128;          co = d % 2;   end
          4: begin r = (d * 2) % 256;                    co = d / 128; end
          5: begin r = d / 2 + (d / 128) * 128;          co = d % 2;   end
          6: begin r = (d * 2) % 256 + 1;                co = d / 128; end
          default: begin r = d / 2;                      co = d % 2;   end
        endcase
        ones = 0;
        for (int i = 0; i < 8; i++) ones += (r >> i) & 1;
        f = (fin & 8'h28) + (r / 128) * 128 + ((r == 0) ? 64 : 0)
            + ((ones % 2 == 0) ? 4 : 0) + co;
      end
      1: begin
        r  = d;
        we = 0;
        f  = (fin & 8'hAD) + ((((d >> b) & 1) == 0) ? 64 : 0) + 16;
      end
      2: r = d & ~(1 << b) & 255;
      default: r = d | (1 << b);
    endcase
    return we * 65536 + f * 256 + r;
  endfunction

  task automatic step(bit v, bit [7:0] op, bit [7:0] d, bit [7:0] f);
    exp_t  e;
    int    pk;
    string tag;
    @(negedge clk);
    in_valid = v; op_code = op; operand = d; flags_in = f;
    #1;
    n_vec++;
    if (src_sel !== op[2:0]) begin
      n_bad++;
      $display("FAIL R7 src_sel act=%0d exp=%0d", src_sel, op[2:0]);
    end
    if (v) begin
      pk  = ref_model(int'(op), int'(d), int'(f));
      m_r = pk[7:0]; m_f = pk[15:8]; m_w = pk[16];
    end
    e.v = v; e.r = m_r; e.f = m_f; e.w = m_w;
    q.push_back(e);
    if (!v) tag = "R8";
    else case (op[7:6])
      2'b00:   tag = (op[5:3] == 3'd6) ? "R3" : "R2/R4";
      2'b01:   tag = "R5";
      default: tag = "R6";
    endcase
    @(posedge clk); #1;
    e = q.pop_front();
    n_vec++;
    if ({out_valid, result, flags_out, wr_en} !== {e.v, e.r, e.f, e.w}) begin
      n_bad++;
      $display("FAIL %s/R1 op=%02h d=%02h act v=%0b r=%02h f=%02h w=%0b exp v=%0b r=%02h f=%02h w=%0b",
               tag, op, d, out_valid, result, flags_out, wr_en, e.v, e.r, e.f, e.w);
    end
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog R1 act=running exp=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    bit [7:0] pats [5] = '{8'h00, 8'hFF, 8'h80, 8'h01, 8'h5A};
    rst_n = 1'b0; in_valid = 1'b0; op_code = 8'h00; operand = 8'h00; flags_in = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    n_vec++;  // R8 reset state
    if ({out_valid, result, flags_out, wr_en} !== 18'd0) begin
      n_bad++;
      $display("FAIL R8 reset act=%05h exp=00000", {out_valid, result, flags_out, wr_en});
    end
    rst_n = 1'b1;
    // directed corner: extra shift of zero and of 0x80 (R3)
    step(1, 8'h37, 8'h00, 8'h00);
    step(1, 8'h30, 8'h80, 8'hFF);
    // exhaustive opcodes, back to back, with idle junk cycles mixed in
    for (int op = 0; op < 256; op++) begin
      for (int k = 0; k < 5; k++) begin
        step(1, 8'(op), pats[k] ^ 8'(k * (op % 3)), lfsr[15:8]);
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        if ((op + k) % 7 == 0) step(0, lfsr[7:0], ~pats[k], lfsr[15:8]);
      end
    end
    step(0, 8'h00, 8'h00, 8'h00);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule